// File: doc/BRIEF.md
# Receive Queue with Hysteresis Flow Control

This block buffers received characters for a serial receiver. Each entry is 11 bits wide: a data byte plus three error flags. The receiver writes entries through a push port, and the host reads them through a pop port. A fill-level output always shows how many entries are held.

A programmable trigger level raises a data-ready interrupt. An active-low flow-control output tells the remote transmitter to pause or resume. This output uses two thresholds, the trigger level plus a hysteresis and the trigger level minus the same hysteresis. Between those thresholds the output keeps its last state, so it does not chatter when the level hovers near the trigger.

Automatic flow control works only when the queue enable, the enhanced-feature enable and the modem-control select are all set.

Top module: `rxq_top`

## Requirements
- R1: The queue holds up to 256 entries of 11 bits each and returns them in arrival order. A pop accepted at a clock edge presents the oldest entry on `popData` after that edge.
- R2: `fillLevel` equals the number of entries held. An accepted push raises it by one and an accepted pop lowers it by one. A push and a pop accepted at the same edge leave it unchanged.
- R3: `rxDataIrq` is high exactly when the queue is enabled and `fillLevel` is greater than or equal to `trigLevel`. It follows the fill level in the same cycle.
- R4: When flow control is active and the fill level sampled at an edge is at or above min(`trigLevel`+`hystAmt`, 256), `flowCtlN` is 1 (pause) after that edge.
- R5: When flow control is active and the fill level sampled at an edge is at or below max(`trigLevel`-`hystAmt`, 0), and R4 does not apply, `flowCtlN` is 0 (ready) after that edge.
- R6: When flow control is active and the sampled fill level lies strictly between the two thresholds, `flowCtlN` keeps its previous value.
- R7: Flow control is active only when `fifoEn`, `autoFlowEn` and `flowSelect` are all 1. Otherwise `flowCtlN` is 0 after the next edge.
- R8: A push while the queue holds 256 entries is dropped, even if a pop is accepted at the same edge. The drop sets `overrun`, which stays set until reset or until the queue is disabled.
- R9: A pop while the queue is empty leaves `popData` and `fillLevel` unchanged.
- R10: While `fifoEn` is 0, each edge empties the queue and clears `overrun`. Pushes and pops are ignored, and `popData` keeps its value.
- R11: After reset, `fillLevel` is 0, `popData` is 0, and `flowCtlN`, `overrun` and `rxDataIrq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fifoEn | input | 1 | Queue enable; 0 empties the queue |
| autoFlowEn | input | 1 | Enhanced-feature enable for automatic flow control |
| flowSelect | input | 1 | Modem-control select for automatic flow control |
| trigLevel | input | 9 | Trigger level, 0 to 256 |
| hystAmt | input | 9 | Hysteresis applied around the trigger level |
| pushValid | input | 1 | Receiver writes `pushData` this cycle |
| pushData | input | 11 | Data byte in bits 7:0, error flags in bits 10:8 |
| popReq | input | 1 | Host reads one entry |
| popData | output | 11 | Last entry popped |
| fillLevel | output | 9 | Number of entries held |
| rxDataIrq | output | 1 | Data-ready interrupt |
| flowCtlN | output | 1 | Active-low flow control; 1 asks the far end to pause |
| overrun | output | 1 | Sticky flag for a dropped push |

## Verification
The hardest states to reach are the saturated thresholds and the full-queue corner. A saturated upper threshold pauses the far end only at 256 entries. A lower threshold of 0 resumes it only when the queue is empty. The bench fills the queue past 256 entries to reach these states, including a cycle that pushes and pops at once while full. It then drains the queue with extra pops on the empty queue, and it repeats this under settings whose sums overflow or whose differences go negative. Long random traffic with occasional disables then checks the hold behaviour near the trigger against a queue-based model on every clock.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  // Per-cycle commands from control to storage
  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
  } rxqStrobe_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int WIDTH = 11,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  rxqStrobe_t       strobe,
  input  logic [WIDTH-1:0] pushData,
  output logic [WIDTH-1:0] popData,
  output logic [CW-1:0]    fillCount
);

  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr;
  logic [AW-1:0]    rdPtr;
  logic [AW-1:0]    wrPtrNext;
  logic [AW-1:0]    rdPtrNext;

  always_comb begin
    wrPtrNext = (wrPtr == LAST_IDX) ? '0 : wrPtr + AW'(1);
    rdPtrNext = (rdPtr == LAST_IDX) ? '0 : rdPtr + AW'(1);
  end

  always_ff @(posedge clk) begin
    if (strobe.push) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillCount <= '0;
      popData   <= '0;
    end else if (strobe.clear) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillCount <= '0;
    end else begin
      if (strobe.push) wrPtr <= wrPtrNext;
      if (strobe.pop) begin
        rdPtr   <= rdPtrNext;
        popData <= mem[rdPtr];
      end
      case ({strobe.push, strobe.pop})
        2'b10:   fillCount <= fillCount + CW'(1);
        2'b01:   fillCount <= fillCount - CW'(1);
        default: fillCount <= fillCount;
      endcase
    end
  end

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= CW'(DEPTH));

  // R9
  pop_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.pop |=> $stable(popData));

  // R2
  step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clear |=> (fillCount == $past(fillCount)) ||
                      (fillCount == $past(fillCount) + CW'(1)) ||
                      (fillCount == $past(fillCount) - CW'(1)));

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          fifoEn,
  input  logic          autoFlowEn,
  input  logic          flowSelect,
  input  logic [CW-1:0] trigLevel,
  input  logic [CW-1:0] hystAmt,
  input  logic          pushValid,
  input  logic          popReq,
  input  logic [CW-1:0] fillCount,
  output rxqStrobe_t    strobe,
  output logic          rxDataIrq,
  output logic          flowCtlN,
  output logic          overrun
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic          isFull;
  logic          isEmpty;
  logic          flowActive;
  logic [CW:0]   upperSum;
  logic [CW-1:0] upperThr;
  logic [CW-1:0] lowerThr;

  always_comb begin
    isFull  = (fillCount == FULL_CNT);
    isEmpty = (fillCount == '0);
    strobe.clear = !fifoEn;
    strobe.push  = fifoEn && pushValid && !isFull;
    strobe.pop   = fifoEn && popReq && !isEmpty;
  end

  // Hysteresis thresholds, clamped to the queue range
  always_comb begin
    upperSum = {1'b0, trigLevel} + {1'b0, hystAmt};
    upperThr = (upperSum > (CW+1)'(DEPTH)) ? FULL_CNT : upperSum[CW-1:0];
    lowerThr = (trigLevel > hystAmt) ? (trigLevel - hystAmt) : '0;
  end

  assign flowActive = fifoEn && autoFlowEn && flowSelect;
  assign rxDataIrq  = fifoEn && (fillCount >= trigLevel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flowCtlN <= 1'b0;
    end else if (!flowActive) begin
      flowCtlN <= 1'b0;
    end else if (fillCount >= upperThr) begin
      flowCtlN <= 1'b1;
    end else if (fillCount <= lowerThr) begin
      flowCtlN <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overrun <= 1'b0;
    end else if (!fifoEn) begin
      overrun <= 1'b0;
    end else if (pushValid && isFull) begin
      overrun <= 1'b1;
    end
  end

  // R8
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fifoEn && pushValid && fillCount == FULL_CNT) |=> overrun);

  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fifoEn && overrun) |=> overrun);

  // R6
  flow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flowActive && fillCount > lowerThr && fillCount < upperThr)
      |=> $stable(flowCtlN));

  // R7
  flow_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoEn || !autoFlowEn || !flowSelect) |=> !flowCtlN);

  // R8
  full_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    isFull |-> !strobe.push);

endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int WIDTH = 11,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoEn,
  input  logic             autoFlowEn,
  input  logic             flowSelect,
  input  logic [CW-1:0]    trigLevel,
  input  logic [CW-1:0]    hystAmt,
  input  logic             pushValid,
  input  logic [WIDTH-1:0] pushData,
  input  logic             popReq,
  output logic [WIDTH-1:0] popData,
  output logic [CW-1:0]    fillLevel,
  output logic             rxDataIrq,
  output logic             flowCtlN,
  output logic             overrun
);

  rxqStrobe_t strobe;

  rxq_ctrl #(.DEPTH(DEPTH)) ctrlUnit (
    .clk        (clk),
    .rstN       (rstN),
    .fifoEn     (fifoEn),
    .autoFlowEn (autoFlowEn),
    .flowSelect (flowSelect),
    .trigLevel  (trigLevel),
    .hystAmt    (hystAmt),
    .pushValid  (pushValid),
    .popReq     (popReq),
    .fillCount  (fillLevel),
    .strobe     (strobe),
    .rxDataIrq  (rxDataIrq),
    .flowCtlN   (flowCtlN),
    .overrun    (overrun)
  );

  rxq_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) storeUnit (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .pushData  (pushData),
    .popData   (popData),
    .fillCount (fillLevel)
  );

endmodule

// File: tb/rxq_top_test.sv
module rxq_top_test;
  localparam int DEPTH = 256;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fifoEn = 1'b0, autoFlowEn = 1'b0, flowSelect = 1'b0;
  logic [8:0]  trigLevel = '0, hystAmt = '0;
  logic        pushValid = 1'b0, popReq = 1'b0;
  logic [10:0] pushData = '0;
  logic [10:0] popData;
  logic [8:0]  fillLevel;
  logic        rxDataIrq, flowCtlN, overrun;

  int compared = 0, mismatched = 0;
  bit done = 0, checking = 0;

  always #2 clk = ~clk;

  rxq_top uut (.*);

  // Reference model
  logic [10:0] q[$];
  int    mPop = 0, mFlow = 0, mOvr = 0;
  string flowTag = "R7", fillTag = "R2", popTag = "R1", ovrTag = "R8";

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      q.delete(); mPop = 0; mFlow = 0; mOvr = 0;
    end else if (!fifoEn) begin
      q.delete(); mFlow = 0; mOvr = 0;
      flowTag = "R10"; fillTag = "R10"; popTag = "R10"; ovrTag = "R10";
    end else begin
      int old, upper, lower;
      old = q.size();
      upper = int'(trigLevel) + int'(hystAmt);
      if (upper > DEPTH) upper = DEPTH;
      lower = int'(trigLevel) - int'(hystAmt);
      if (lower < 0) lower = 0;
      if (!(autoFlowEn && flowSelect)) begin mFlow = 0; flowTag = "R7"; end
      else if (old >= upper) begin mFlow = 1; flowTag = "R4"; end
      else if (old <= lower) begin mFlow = 0; flowTag = "R5"; end
      else flowTag = "R6";
      fillTag = "R2"; popTag = "R1"; ovrTag = "R8";
      if (pushValid && old == DEPTH) mOvr = 1;
      if (popReq && old == 0) begin fillTag = "R9"; popTag = "R9"; end
      if (popReq && old > 0) mPop = int'(q.pop_front());
      if (pushValid && old < DEPTH) q.push_back(pushData);
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (checking) begin
    chk(popTag, "popData", int'(popData), mPop);
    chk(fillTag, "fillLevel", int'(fillLevel), q.size());
    chk("R3", "rxDataIrq", int'(rxDataIrq),
        int'(fifoEn && q.size() >= int'(trigLevel)));
    chk(flowTag, "flowCtlN", int'(flowCtlN), mFlow);
    chk(ovrTag, "overrun", int'(overrun), mOvr);
  end

  task automatic cyc(bit pv, int pd, bit pr);
    @(negedge clk); #1;
    pushValid = pv; pushData = 11'(pd); popReq = pr;
  endtask

  task automatic cfg(bit en, bit af, bit fs, int trg, int hys);
    @(negedge clk); #1;
    fifoEn = en; autoFlowEn = af; flowSelect = fs;
    trigLevel = 9'(trg); hystAmt = 9'(hys);
    pushValid = 0; popReq = 0;
  endtask

  task automatic fillDrain(int nPush, int nPop);
    for (int i = 0; i < nPush; i++) cyc(1, (i * 37 + 5) & 11'h7ff, 0);
    for (int i = 0; i < nPop; i++) cyc(0, 0, 1);
    cyc(0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "fillLevel", int'(fillLevel), 0);
    chk("R11", "popData", int'(popData), 0);
    chk("R11", "flowCtlN", int'(flowCtlN), 0);
    chk("R11", "overrun", int'(overrun), 0);
    chk("R11", "rxDataIrq", int'(rxDataIrq), 0);
    #1 rstN = 1;
    checking = 1;

    // R4/R5/R8/R9: trigger 128, hysteresis 32, overfill and over-drain
    cfg(1, 1, 1, 128, 32);
    fillDrain(260, 0);
    cyc(1, 11'h155, 1);     // R8 push+pop while full
    cyc(0, 0, 0);
    fillDrain(0, 262);
    // R10 disable clears overrun, ignores traffic
    cfg(0, 1, 1, 128, 32);
    cyc(1, 3, 1); cyc(1, 4, 0); cyc(0, 0, 0);
    // R4 saturated upper threshold
    cfg(1, 1, 1, 200, 100);
    fillDrain(256, 257);
    // R5 lower threshold clamps at zero
    cfg(1, 1, 1, 20, 50);
    fillDrain(40, 41);
    // R7 select missing
    cfg(1, 1, 0, 50, 10);
    fillDrain(200, 200);
    cfg(1, 0, 1, 50, 10);
    fillDrain(100, 100);
    // R6 random traffic near trigger, rare disables
    cfg(1, 1, 1, 64, 16);
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r == 0) begin
        cfg(0, 1, 1, 64, 16);
        cfg(1, 1, 1, 64, 16);
      end else begin
        cyc(r < 55, $urandom_range(0, 2047), r >= 45);
      end
    end
    // zero hysteresis, bursty
    cfg(1, 1, 1, 10, 0);
    for (int i = 0; i < 1000; i++) cyc((i % 40) < 22, i, (i % 30) >= 14);
    fillDrain(0, 300);
    repeat (2) @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule